// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block steers program flow into and out of privileged mode. Each cycle it samples an encoded event code, the PC of the instruction being executed, the base address of the privileged handler area and a return-from-exception request. When an event is taken it computes the handler address, which is the base plus a fixed per-event offset. It records the restart address in an exception-address register and switches the integer register file over to its shadow bank. A return request in privileged mode sends flow back to the saved address. The shadow bank is released only when that address is not itself a privileged address.

Bit 0 of a PC marks privileged mode. Faults save the PC of the causing instruction so that it runs again. The two trap classes, privileged call and arithmetic, save PC+4 so that the causing instruction is skipped. All outputs are registered: the redirect, handler PC, following PC and bank state appear on the clock edge that samples the event. A small decode tells the register file whether a given register index currently reads from the shadow bank.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is held, `redirect` is 0, `shadow_active` is 1 and `exc_addr` is 0. On the first clock edge after reset is released, `redirect` pulses, `next_pc` = `priv_base` + 0x0001 and `next_npc` = `next_pc` + 4. That edge ignores all other inputs and leaves `exc_addr` at 0.
- R2: Event codes and their handler offsets from `priv_base`:
  - 1 reset: 0x0001
  - 2 machine check: 0x0401
  - 3 arithmetic: 0x0501
  - 4 interrupt: 0x0101
  - 5 user data-TLB miss: 0x0201
  - 6 kernel data-TLB miss: 0x0281
  - 7 alignment: 0x0301
  - 8 data-TLB fault and 9 data access violation: 0x0381
  - 10 instruction-TLB miss and 11 instruction-TLB fault: 0x0181
  - 12 instruction access violation: 0x0081
  - 13 illegal operation: 0x0481
  - 14 FP disabled: 0x0581
  - 15 privileged call: 0x2001
  - 16 integer overflow: 0x0501
- R3: A taken event or return makes `redirect` 1 for exactly the following edge's cycle, with `next_npc` = `next_pc` + 4. All address sums wrap modulo 2^ADDR_W.
- R4: A taken event loads `exc_addr` with `pc_in`, with one exception. Event 4 with `pc_in[0]`=1 leaves `exc_addr` unchanged.
- R5: Events 15 and 3 are traps and load `exc_addr` with `pc_in` + 4. Every other event, including 16, saves `pc_in` unchanged.
- R6: Every taken event sets `shadow_active`. `bank_err` pulses when an event other than the post-reset entry is taken while `shadow_active` is already 1.
- R7: When `rfe_req`=1, no event is present and `pc_in[0]`=1, `next_pc` is loaded with `exc_addr`. `shadow_active` clears only if `exc_addr[0]`=0, and `bank_err` pulses if that release happens while `shadow_active` is already 0.
- R8: When `rfe_req`=1, no event is present and `pc_in[0]`=0, the block takes event 13. The handler is at offset 0x0481 and `exc_addr` is loaded with `pc_in`.
- R9: A valid event code (1 to 16) takes priority over `rfe_req` in the same cycle. Codes 0 and 17 to 31 without `rfe_req` change nothing: `redirect` stays 0, and `exc_addr` and `shadow_active` hold.
- R10: `reg_shadow` = `shadow_active` AND (`reg_idx` in 8..14 or `reg_idx` = 25).
- R11: `unsup_trap` pulses together with the redirect for event 3 only; the entry is still performed.
- R12: `in_priv` equals `pc_in[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_code | input | 5 | Encoded event, 0 = none |
| rfe_req | input | 1 | Return-from-exception request |
| pc_in | input | ADDR_W | PC of the executing instruction |
| priv_base | input | ADDR_W | Handler area base address |
| reg_idx | input | IDX_W | Register index to classify |
| redirect | output | 1 | Next PC pair is valid this cycle |
| next_pc | output | ADDR_W | Redirect target |
| next_npc | output | ADDR_W | Target plus 4 |
| exc_addr | output | ADDR_W | Saved restart address |
| shadow_active | output | 1 | Shadow bank selected |
| reg_shadow | output | 1 | `reg_idx` reads the shadow bank |
| in_priv | output | 1 | Privileged mode flag |
| bank_err | output | 1 | Redundant bank switch request |
| unsup_trap | output | 1 | Arithmetic trap flagged unsupported |

## Verification
The bench builds the block with ADDR_W = 16, so every offset fits and sums can carry out of the top bit. One base value sits high enough that the privileged-call vector wraps past zero. All 32 event codes are swept with both privileged-mode settings of `pc_in` and against three base values, which covers every table entry, the ignored codes and the interrupt-in-privileged-mode exception. Return requests are run from both modes, with saved addresses of both bit-0 values and with the bank both set and clear. All 32 register indices are classified with the bank on and off.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int CODE_W = 5;
    localparam int VEC_W  = 14;

    typedef enum logic [CODE_W-1:0] {
        EV_NONE        = 5'd0,
        EV_RESET       = 5'd1,
        EV_MCHK        = 5'd2,
        EV_ARITH       = 5'd3,
        EV_INTR        = 5'd4,
        EV_DMISS_USER  = 5'd5,
        EV_DMISS_KERN  = 5'd6,
        EV_ALIGN       = 5'd7,
        EV_DFAULT      = 5'd8,
        EV_DACV        = 5'd9,
        EV_IMISS       = 5'd10,
        EV_IFAULT      = 5'd11,
        EV_IACV        = 5'd12,
        EV_ILLEGAL     = 5'd13,
        EV_FP_OFF      = 5'd14,
        EV_PRIV_CALL   = 5'd15,
        EV_INT_OVF     = 5'd16
    } ev_code_e;
endpackage

// File: rtl/trap_vector_rom.sv
module trap_vector_rom
    import trap_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [VEC_W-1:0]  offset,
    output logic              known,
    output logic              is_trap,
    output logic              unsupported
);
    always_comb begin
        known       = 1'b1;
        is_trap     = 1'b0;
        unsupported = 1'b0;
        offset      = '0;
        case (code)
            EV_RESET:                 offset = 14'h0001;
            EV_MCHK:                  offset = 14'h0401;
            EV_ARITH: begin
                offset      = 14'h0501;
                is_trap     = 1'b1;
                unsupported = 1'b1;
            end
            EV_INT_OVF:               offset = 14'h0501;
            EV_INTR:                  offset = 14'h0101;
            EV_DMISS_USER:            offset = 14'h0201;
            EV_DMISS_KERN:            offset = 14'h0281;
            EV_ALIGN:                 offset = 14'h0301;
            EV_DFAULT, EV_DACV:       offset = 14'h0381;
            EV_IMISS, EV_IFAULT:      offset = 14'h0181;
            EV_IACV:                  offset = 14'h0081;
            EV_ILLEGAL:               offset = 14'h0481;
            EV_FP_OFF:                offset = 14'h0581;
            EV_PRIV_CALL: begin
                offset  = 14'h2001;
                is_trap = 1'b1;
            end
            default:                  known = 1'b0;
        endcase
    end
endmodule

// File: rtl/shadow_map.sv
module shadow_map #(
    parameter int NREG      = 32,
    parameter int RANGE_LO  = 8,
    parameter int RANGE_HI  = 14,
    parameter int EXTRA_IDX = 25,
    localparam int IDX_W    = $clog2(NREG)
) (
    input  logic [IDX_W-1:0] idx,
    output logic             shadowed
);
    logic [NREG-1:0] mask;

    for (genvar i = 0; i < NREG; i++) begin : g_mask
        assign mask[i] = ((i >= RANGE_LO) && (i <= RANGE_HI)) || (i == EXTRA_IDX);
    end

    assign shadowed = mask[idx];
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4,
    parameter int NREG        = 32,
    localparam int IDX_W      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] event_code,
    input  logic              rfe_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] priv_base,
    input  logic [IDX_W-1:0]  reg_idx,
    output logic              redirect,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] next_npc,
    output logic [ADDR_W-1:0] exc_addr,
    output logic              shadow_active,
    output logic              reg_shadow,
    output logic              in_priv,
    output logic              bank_err,
    output logic              unsup_trap
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    typedef struct packed {
        logic              boot;
        logic              redirect;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic [ADDR_W-1:0] exc;
        logic              shadow;
        logic              err;
        logic              unsup;
    } state_t;

    state_t st_d, st_q;

    logic [CODE_W-1:0] eff_code;
    logic [VEC_W-1:0]  vec_off;
    logic              vec_known, vec_trap, vec_unsup;
    logic              ev_known_in, rfe_illegal, take_entry, take_return;
    logic              in_known, in_trap, in_unsup;
    logic [VEC_W-1:0]  in_off;
    logic              idx_shadowed;

    // classify the raw input code
    trap_vector_rom u_in_rom (
        .code        (event_code),
        .offset      (in_off),
        .known       (in_known),
        .is_trap     (in_trap),
        .unsupported (in_unsup)
    );

    assign ev_known_in = in_known;
    assign rfe_illegal = rfe_req && !ev_known_in && !pc_in[0];
    assign eff_code    = st_q.boot   ? EV_RESET   :
                         rfe_illegal ? EV_ILLEGAL : event_code;

    trap_vector_rom u_vec_rom (
        .code        (eff_code),
        .offset      (vec_off),
        .known       (vec_known),
        .is_trap     (vec_trap),
        .unsupported (vec_unsup)
    );

    assign take_entry  = vec_known && (st_q.boot || ev_known_in || rfe_illegal);
    assign take_return = !st_q.boot && !ev_known_in && rfe_req && pc_in[0];

    always_comb begin
        st_d          = st_q;
        st_d.boot     = 1'b0;
        st_d.redirect = 1'b0;
        st_d.err      = 1'b0;
        st_d.unsup    = 1'b0;
        if (take_entry) begin
            st_d.redirect = 1'b1;
            st_d.pc       = priv_base + ADDR_W'(vec_off);
            st_d.shadow   = 1'b1;
            if (!st_q.boot) begin
                st_d.err   = st_q.shadow;
                st_d.unsup = vec_unsup;
                if (!((eff_code == EV_INTR) && pc_in[0]))
                    st_d.exc = vec_trap ? (pc_in + STEP) : pc_in;
            end
        end else if (take_return) begin
            st_d.redirect = 1'b1;
            st_d.pc       = st_q.exc;
            if (!st_q.exc[0]) begin
                st_d.shadow = 1'b0;
                st_d.err    = !st_q.shadow;
            end
        end
        st_d.npc = st_d.pc + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.boot   <= 1'b1;
            st_q.shadow <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    shadow_map #(.NREG(NREG)) u_map (
        .idx      (reg_idx),
        .shadowed (idx_shadowed)
    );

    assign redirect      = st_q.redirect;
    assign next_pc       = st_q.pc;
    assign next_npc      = st_q.npc;
    assign exc_addr      = st_q.exc;
    assign shadow_active = st_q.shadow;
    assign reg_shadow    = st_q.shadow && idx_shadowed;
    assign in_priv       = pc_in[0];
    assign bank_err      = st_q.err;
    assign unsup_trap    = st_q.unsup;

    // R6: every non-boot entry leaves the shadow bank selected
    a_r6_entry_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.boot && in_known) |=> (shadow_active && redirect));

    // R8: a return from user mode is redirected to the illegal-operation handler
    a_r8_user_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.boot && rfe_req && event_code == 5'd0 && !pc_in[0])
        |=> (redirect && next_pc == $past(priv_base) + ADDR_W'(14'h0481)));

    // R9: idle and unknown codes disturb nothing
    a_r9_ignored_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.boot && !rfe_req && !in_known)
        |=> (!redirect && $stable(exc_addr) && $stable(shadow_active)));

    // R4: an interrupt taken in privileged mode keeps the saved address
    a_r4_intr_priv_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.boot && event_code == 5'd4 && pc_in[0]) |=> $stable(exc_addr));

    // R7: a return to a privileged address keeps the bank selection
    a_r7_return_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.boot && rfe_req && event_code == 5'd0 && pc_in[0] && exc_addr[0])
        |=> (redirect && $stable(shadow_active)));

    // R3: redirect lasts only while a request is present
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !st_q.boot && !rfe_req && !in_known) |=> !redirect);
endmodule

// File: tb/trap_entry_ctrl_test.sv
module trap_entry_ctrl_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    event_code = '0;
    logic          rfe_req = 1'b0;
    logic [AW-1:0] pc_in = '0;
    logic [AW-1:0] priv_base = 16'h1000;
    logic [4:0]    reg_idx = '0;
    logic          redirect, shadow_active, reg_shadow, in_priv, bank_err, unsup_trap;
    logic [AW-1:0] next_pc, next_npc, exc_addr;

    int checks = 0;
    int errors = 0;
    logic          m_shadow;
    logic [AW-1:0] m_exc;
    logic [AW-1:0] m_pc;

    always #2.5 clk = ~clk;

    trap_entry_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .event_code(event_code), .rfe_req(rfe_req),
        .pc_in(pc_in), .priv_base(priv_base), .reg_idx(reg_idx),
        .redirect(redirect), .next_pc(next_pc), .next_npc(next_npc),
        .exc_addr(exc_addr), .shadow_active(shadow_active), .reg_shadow(reg_shadow),
        .in_priv(in_priv), .bank_err(bank_err), .unsup_trap(unsup_trap)
    );

    function automatic logic [13:0] vec(input logic [4:0] c);
        case (c)
            5'd1: vec = 14'h0001;  5'd2: vec = 14'h0401;
            5'd3: vec = 14'h0501;  5'd4: vec = 14'h0101;
            5'd5: vec = 14'h0201;  5'd6: vec = 14'h0281;
            5'd7: vec = 14'h0301;  5'd8: vec = 14'h0381;
            5'd9: vec = 14'h0381;  5'd10: vec = 14'h0181;
            5'd11: vec = 14'h0181; 5'd12: vec = 14'h0081;
            5'd13: vec = 14'h0481; 5'd14: vec = 14'h0581;
            5'd15: vec = 14'h2001; 5'd16: vec = 14'h0501;
            default: vec = 14'h0000;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] code, input logic rfe, input logic [AW-1:0] pc,
                        input logic [AW-1:0] base);
        logic          valid, e_red, e_err, e_uns, rel;
        logic [4:0]    eff;
        logic [AW-1:0] e_pc;
        @(negedge clk);
        event_code = code; rfe_req = rfe; pc_in = pc; priv_base = base;
        #1;
        chk(in_priv == pc[0], "R12 in_priv", {31'd0, in_priv}, {31'd0, pc[0]});
        @(posedge clk); #1;
        valid = (code >= 5'd1 && code <= 5'd16);
        eff = code;
        if (!valid && rfe && !pc[0]) begin eff = 5'd13; valid = 1'b1; end
        e_red = 1'b0; e_err = 1'b0; e_uns = 1'b0; e_pc = m_pc;
        if (valid) begin
            e_red = 1'b1;
            e_pc  = base + AW'(vec(eff));
            e_err = m_shadow;
            e_uns = (eff == 5'd3);
            if (!(eff == 5'd4 && pc[0]))
                m_exc = (eff == 5'd15 || eff == 5'd3) ? pc + 16'd4 : pc;
            m_shadow = 1'b1;
        end else if (rfe) begin
            e_red = 1'b1;
            e_pc  = m_exc;
            rel   = !m_exc[0];
            e_err = rel && !m_shadow;
            if (rel) m_shadow = 1'b0;
        end
        m_pc = e_pc;
        chk(redirect == e_red, "R3/R9 redirect", {31'd0, redirect}, {31'd0, e_red});
        if (e_red) begin
            chk(next_pc == e_pc, "R2/R7/R8 next_pc", {16'd0, next_pc}, {16'd0, e_pc});
            chk(next_npc == e_pc + 16'd4, "R3 next_npc", {16'd0, next_npc}, {16'd0, e_pc + 16'd4});
        end
        chk(exc_addr == m_exc, "R4/R5 exc_addr", {16'd0, exc_addr}, {16'd0, m_exc});
        chk(shadow_active == m_shadow, "R6/R7 shadow", {31'd0, shadow_active}, {31'd0, m_shadow});
        chk(bank_err == e_err, "R6/R7 bank_err", {31'd0, bank_err}, {31'd0, e_err});
        chk(unsup_trap == e_uns, "R11 unsup", {31'd0, unsup_trap}, {31'd0, e_uns});
    endtask

    task automatic idx_sweep;
        for (int i = 0; i < 32; i++) begin
            logic e;
            reg_idx = 5'(i);
            #1;
            e = m_shadow && ((i >= 8 && i <= 14) || i == 25);
            chk(reg_shadow == e, "R10 reg_shadow", {31'd0, reg_shadow}, {31'd0, e});
        end
    endtask

    initial begin
        #10000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] bases [3];
        bases[0] = 16'h0000; bases[1] = 16'hE000; bases[2] = 16'h5A5C;
        repeat (3) @(posedge clk);
        #1;
        chk(redirect == 1'b0, "R1 reset redirect", {31'd0, redirect}, 32'd0);
        chk(shadow_active == 1'b1, "R1 reset shadow", {31'd0, shadow_active}, 32'd1);
        chk(exc_addr == '0, "R1 reset exc", {16'd0, exc_addr}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        event_code = 5'd7; rfe_req = 1'b1;   // must be ignored on the boot edge (R1)
        @(posedge clk); #1;
        chk(redirect == 1'b1, "R1 boot redirect", {31'd0, redirect}, 32'd1);
        chk(next_pc == 16'h1001, "R1 boot pc", {16'd0, next_pc}, 32'h1001);
        chk(next_npc == 16'h1005, "R1 boot npc", {16'd0, next_npc}, 32'h1005);
        chk(exc_addr == '0, "R1 boot exc", {16'd0, exc_addr}, 32'd0);
        chk(bank_err == 1'b0, "R1 boot err", {31'd0, bank_err}, 32'd0);
        m_shadow = 1'b1; m_exc = '0; m_pc = 16'h1001;
        idx_sweep();

        // R2 R4 R5 R6 R9 R11: full code sweep, both modes, three bases
        for (int b = 0; b < 3; b++) begin
            for (int c = 0; c < 32; c++) begin
                for (int p = 0; p < 2; p++) begin
                    step(5'(c), 1'b0, (16'h3210 ^ 16'(c << 4)) | 16'(p), bases[b]);
                    step(5'd0, 1'b0, 16'h0100, bases[b]);
                end
            end
        end

        // R7: return to user address releases the bank
        step(5'd7, 1'b0, 16'h4000, 16'h2000);
        step(5'd0, 1'b1, 16'h2301, 16'h2000);
        idx_sweep();
        // R7: second release while bank already clear flags an error
        step(5'd0, 1'b1, 16'h2301, 16'h2000);
        // R5/R7: trap from privileged code, return keeps the bank
        step(5'd15, 1'b0, 16'h3001, 16'h2000);
        step(5'd0, 1'b1, 16'h2001, 16'h2000);
        idx_sweep();
        // R8: return request from user mode
        step(5'd0, 1'b1, 16'h0444, 16'h2000);
        // R9: event wins over return in the same cycle
        step(5'd2, 1'b1, 16'h0881, 16'h2000);
        step(5'd20, 1'b1, 16'h0AA0, 16'h2000);
        step(5'd31, 1'b1, 16'h0AA1, 16'h2000);
        // R4: interrupt in privileged mode
        step(5'd4, 1'b0, 16'h7771, 16'h2000);
        step(5'd4, 1'b0, 16'h7770, 16'h2000);
        step(5'd0, 1'b0, 16'h0000, 16'h2000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule